// File: doc/BRIEF.md
# Quadrature Position Counter Register Front End

This block is the software-facing side of a quadrature position counter. It holds the control word that configures a separate counter core, a status word of sticky event flags, and a 32-bit holding register for count values. A simple synchronous register bus reaches all three. The block does not decode edges and does not count. It takes the live count and the event pulses from the core, and it sends back two things: a preload strobe with the holding-register value, and a latch strobe.

Bus accesses pass through a two-state handshake machine. In `ST_IDLE` a request is accepted: a write takes effect at that edge, or the read data is registered. The transition idle-to-ack is taken on an accepted request. In `ST_ACK` the acknowledge is high for exactly one cycle, any request is ignored, and the machine always returns to `ST_IDLE` at the next edge (transition ack-to-idle).

The status flags follow their set sources: the decode-error, overflow and underflow pulses, a level-sensitive index condition, and a live equality compare between the count and the holding register. Each flag is cleared by writing one to it. A single interrupt line combines the flags with their enables.

Top module: `qdr_regif`

## Requirements
- R1: After reset, the control word (byte offset 0x00), status word (0x04) and holding register (0x08) all read 0, and `irq`, `preload_stb` and `latch_stb` are low.
- R2: Control bits 15:0, except bits 5 and 8, read back exactly as written and appear on `ctrl_o`. Control bits 31:16 read 0 and ignore writes.
- R3: Writing 1 to control bit 5 raises `preload_stb` for exactly one cycle while `preload_val` carries the holding register. The bit reads back 0.
- R4: Writing 1 to control bit 8 copies `core_count` into the holding register and raises `latch_stb` for exactly one cycle. The bit reads back 0.
- R5: The holding register reads back the last 32-bit value written to it.
- R6: Status bit 0 is set by `evt_err`, bit 1 by `evt_ovf` and bit 2 by `evt_unf`. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Bits 31:5 read 0.
- R7: When a set source is active in the same cycle as a write-one-to-clear of that bit, the bit stays set.
- R8: `irq` is high exactly when an enabled status bit is set. The enable pairs are: bit 0 with control 12, bit 1 with control 7, bit 2 with control 6, bit 3 with control 4, and bit 4 with control 15.
- R9: Status bit 3 is set every cycle that `idx_active` is high while control bit 2 is 1. A clear during that time is overridden, and the bit stays clear only once `idx_active` is low.
- R10: Status bit 4 sets when control bit 14 is 1 and `core_count` equals the holding register. It does not set when the two differ or when bit 14 is 0.
- R11: With control bits 2 and 13 set, a rising index condition copies `core_count` into the holding register. With bit 13 clear, the holding register is untouched.
- R12: A request accepted in `ST_IDLE` gives `bus_ack` for exactly one cycle after it, with registered `bus_rdata`. Addresses other than 0x0, 0x4 and 0x8 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one-cycle pulse |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Access complete |
| bus_rdata | output | DATA_W | Registered read data |
| core_count | input | DATA_W | Live count from the counter core |
| evt_err | input | 1 | Decode error pulse |
| evt_ovf | input | 1 | Count wrap upward pulse |
| evt_unf | input | 1 | Count wrap downward pulse |
| idx_active | input | 1 | Index condition currently present |
| ctrl_o | output | 16 | Control word toward the core |
| preload_stb | output | 1 | Load holding register into count |
| preload_val | output | DATA_W | Value to be loaded |
| latch_stb | output | 1 | Count captured into holding register |
| irq | output | 1 | Interrupt request |

## Verification
The two functions most likely to collide are an event setting a status flag and a bus write clearing that same flag. The bench provokes this by driving an underflow pulse in the very cycle that a write-one-to-clear of bit 2 is accepted. It then judges the outcome by reading the status word back, where bit 2 must still be set. The index flag is a standing form of the same collision: while the index condition persists, every clear must be overridden, and the flag may drop only after the condition goes away.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    // Register byte offsets
    localparam int unsigned OFS_CTRL = 0;
    localparam int unsigned OFS_STAT = 4;
    localparam int unsigned OFS_HOLD = 8;

    localparam int unsigned CTRL_W = 16;
    localparam int unsigned STAT_W = 5;

    // Control word bit positions
    localparam int unsigned C_RUN      = 0;
    localparam int unsigned C_DIR      = 1;
    localparam int unsigned C_IDX_EN   = 2;
    localparam int unsigned C_IDX_CLR  = 3;
    localparam int unsigned C_IDX_IE   = 4;
    localparam int unsigned C_LOAD     = 5;
    localparam int unsigned C_UNF_IE   = 6;
    localparam int unsigned C_OVF_IE   = 7;
    localparam int unsigned C_SNAP     = 8;
    localparam int unsigned C_IDX_A    = 9;
    localparam int unsigned C_IDX_B    = 10;
    localparam int unsigned C_IDX_LVL  = 11;
    localparam int unsigned C_ERR_IE   = 12;
    localparam int unsigned C_IDX_SNAP = 13;
    localparam int unsigned C_CMP_EN   = 14;
    localparam int unsigned C_CMP_IE   = 15;

    // Status word bit positions
    localparam int unsigned S_ERR = 0;
    localparam int unsigned S_OVF = 1;
    localparam int unsigned S_UNF = 2;
    localparam int unsigned S_IDX = 3;
    localparam int unsigned S_CMP = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic ctrl;
        logic stat;
        logic hold;
    } reg_sel_t;

endpackage

// File: rtl/qdr_bus_fsm.sv
module qdr_bus_fsm
    import qdr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] rd_ctrl,
    input  logic [DATA_W-1:0] rd_stat,
    input  logic [DATA_W-1:0] rd_hold,
    output reg_sel_t          wr_sel,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(OFS_HOLD);

    bus_state_e state_q, state_d;
    logic       accept;
    reg_sel_t   hit;

    assign accept = (state_q == ST_IDLE) && bus_req;

    always_comb begin
        hit.ctrl = (bus_addr == A_CTRL);
        hit.stat = (bus_addr == A_STAT);
        hit.hold = (bus_addr == A_HOLD);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_req) state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_ack     = 1'b0;
        wr_sel      = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && bus_we) wr_sel = hit;
            end
            ST_ACK:  bus_ack = 1'b1;
            default: bus_ack = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (accept && !bus_we) begin
            if (hit.ctrl)      bus_rdata <= rd_ctrl;
            else if (hit.stat) bus_rdata <= rd_stat;
            else if (hit.hold) bus_rdata <= rd_hold;
            else               bus_rdata <= '0;
        end
    end

    // R12
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R12
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> bus_ack);

endmodule

// File: rtl/qdr_ctrl_regs.sv
module qdr_ctrl_regs
    import qdr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_hold,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] core_count,
    input  logic              idx_active,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] hold_q,
    output logic              preload_stb,
    output logic              latch_stb
);

    localparam logic [CTRL_W-1:0] CMD_MASK =
        CTRL_W'((32'd1 << C_LOAD) | (32'd1 << C_SNAP));

    logic do_load, do_snap, idx_hit, idx_q, idx_rise;

    assign do_load  = wr_ctrl && wr_data[C_LOAD];
    assign do_snap  = wr_ctrl && wr_data[C_SNAP];
    assign idx_hit  = idx_active && ctrl_q[C_IDX_EN];
    assign idx_rise = idx_hit && !idx_q;

    // Configuration bits; command bits never stored
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0] & ~CMD_MASK;
    end

    // One-cycle command strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload_stb <= 1'b0;
            latch_stb   <= 1'b0;
        end else begin
            preload_stb <= do_load;
            latch_stb   <= do_snap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= 1'b0;
        else        idx_q <= idx_hit;
    end

    // Holding register: bus write, then latch command, then index capture
    always_ff @(posedge clk) begin
        if (!rst_n)                              hold_q <= '0;
        else if (wr_hold)                        hold_q <= wr_data;
        else if (do_snap)                        hold_q <= core_count;
        else if (idx_rise && ctrl_q[C_IDX_SNAP]) hold_q <= core_count;
    end

    // R3
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preload_stb |=> !preload_stb);

    // R4
    snap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> !latch_stb);

    // R4
    snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_stb) |-> hold_q == $past(core_count));

endmodule

// File: rtl/qdr_status.sv
module qdr_status
    import qdr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic [STAT_W-1:0] wr_bits,
    input  logic              evt_err,
    input  logic              evt_ovf,
    input  logic              evt_unf,
    input  logic              idx_active,
    input  logic              idx_en,
    input  logic              cmp_en,
    input  logic [STAT_W-1:0] irq_en,
    input  logic [DATA_W-1:0] core_count,
    input  logic [DATA_W-1:0] hold_q,
    output logic [STAT_W-1:0] stat_q,
    output logic              irq
);

    logic [STAT_W-1:0] set_v;
    logic [STAT_W-1:0] clr_v;
    logic              match;

    assign match = (core_count == hold_q);

    always_comb begin
        set_v        = '0;
        set_v[S_ERR] = evt_err;
        set_v[S_OVF] = evt_ovf;
        set_v[S_UNF] = evt_unf;
        set_v[S_IDX] = idx_active && idx_en;
        set_v[S_CMP] = cmp_en && match;
    end

    assign clr_v = wr_stat ? wr_bits : '0;

    // Each flag: set dominates clear
    for (genvar i = 0; i < STAT_W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)        stat_q[i] <= 1'b0;
            else if (set_v[i]) stat_q[i] <= 1'b1;
            else if (clr_v[i]) stat_q[i] <= 1'b0;
        end
    end

    assign irq = |(stat_q & irq_en);

    // R6
    ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ovf |=> stat_q[S_OVF]);

    // R7
    unf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_unf && wr_stat && wr_bits[S_UNF]) |=> stat_q[S_UNF]);

    // R9
    idx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_active && idx_en) |=> stat_q[S_IDX]);

    // R10
    cmp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[S_CMP]) |-> $past(cmp_en && (core_count == hold_q)));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq);

endmodule

// File: rtl/qdr_regif.sv
module qdr_regif
    import qdr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] core_count,
    input  logic              evt_err,
    input  logic              evt_ovf,
    input  logic              evt_unf,
    input  logic              idx_active,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              preload_stb,
    output logic [DATA_W-1:0] preload_val,
    output logic              latch_stb,
    output logic              irq
);

    localparam int unsigned PAD_C = DATA_W - CTRL_W;
    localparam int unsigned PAD_S = DATA_W - STAT_W;

    reg_sel_t          wr_sel;
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] stat_q;
    logic [DATA_W-1:0] hold_q;
    logic [STAT_W-1:0] irq_en;

    always_comb begin
        irq_en        = '0;
        irq_en[S_ERR] = ctrl_q[C_ERR_IE];
        irq_en[S_OVF] = ctrl_q[C_OVF_IE];
        irq_en[S_UNF] = ctrl_q[C_UNF_IE];
        irq_en[S_IDX] = ctrl_q[C_IDX_IE];
        irq_en[S_CMP] = ctrl_q[C_CMP_IE];
    end

    qdr_bus_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .rd_ctrl   ({{PAD_C{1'b0}}, ctrl_q}),
        .rd_stat   ({{PAD_S{1'b0}}, stat_q}),
        .rd_hold   (hold_q),
        .wr_sel    (wr_sel),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

    qdr_ctrl_regs #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_sel.ctrl),
        .wr_hold     (wr_sel.hold),
        .wr_data     (bus_wdata),
        .core_count  (core_count),
        .idx_active  (idx_active),
        .ctrl_q      (ctrl_q),
        .hold_q      (hold_q),
        .preload_stb (preload_stb),
        .latch_stb   (latch_stb)
    );

    qdr_status #(
        .DATA_W (DATA_W)
    ) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stat    (wr_sel.stat),
        .wr_bits    (bus_wdata[STAT_W-1:0]),
        .evt_err    (evt_err),
        .evt_ovf    (evt_ovf),
        .evt_unf    (evt_unf),
        .idx_active (idx_active),
        .idx_en     (ctrl_q[C_IDX_EN]),
        .cmp_en     (ctrl_q[C_CMP_EN]),
        .irq_en     (irq_en),
        .core_count (core_count),
        .hold_q     (hold_q),
        .stat_q     (stat_q),
        .irq        (irq)
    );

    assign ctrl_o      = ctrl_q;
    assign preload_val = hold_q;

endmodule

// File: tb/test_qdr_regif.sv
module test_qdr_regif;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_ack;
    logic [DATA_W-1:0] bus_rdata;
    logic [DATA_W-1:0] core_count;
    logic              evt_err = 1'b0, evt_ovf = 1'b0, evt_unf = 1'b0;
    logic              idx_active = 1'b0;
    logic [15:0]       ctrl_o;
    logic              preload_stb, latch_stb, irq;
    logic [DATA_W-1:0] preload_val;
    logic              step_up = 1'b0;

    int checks = 0;
    int errors = 0;
    logic              obs_pre1, obs_pre2, obs_lat1, obs_lat2, obs_ack1, obs_ack2;
    logic [DATA_W-1:0] obs_pval;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Counter core stand-in
    always @(posedge clk) begin
        if (!rst_n)           core_count <= '0;
        else if (preload_stb) core_count <= preload_val;
        else if (step_up)     core_count <= core_count + 1;
    end

    qdr_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_qdr_regif (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .core_count(core_count), .evt_err(evt_err),
        .evt_ovf(evt_ovf), .evt_unf(evt_unf), .idx_active(idx_active),
        .ctrl_o(ctrl_o), .preload_stb(preload_stb), .preload_val(preload_val),
        .latch_stb(latch_stb), .irq(irq)
    );

    task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
        obs_ack1 = bus_ack; obs_pre1 = preload_stb; obs_lat1 = latch_stb;
        obs_pval = preload_val;
        @(posedge clk); #1;
        obs_ack2 = bus_ack; obs_pre2 = preload_stb; obs_lat2 = latch_stb;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_req = 1'b0;
        d = bus_rdata;
        @(posedge clk); #1;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: evt_err = 1'b1;
            1: evt_ovf = 1'b1;
            default: evt_unf = 1'b1;
        endcase
        @(negedge clk);
        evt_err = 1'b0; evt_ovf = 1'b0; evt_unf = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rd;
        logic [DATA_W-1:0] exp;
        int en_pos[3];
        en_pos[0] = 12; en_pos[1] = 7; en_pos[2] = 6;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 strobes", {30'd0, preload_stb, latch_stb}, 0);
        bus_rd(4'h0, rd); chk("R1 ctrl", rd, 0);
        bus_rd(4'h4, rd); chk("R1 stat", rd, 0);
        bus_rd(4'h8, rd); chk("R1 hold", rd, 0);

        // R2 sweep every control bit
        for (int b = 0; b < 16; b++) begin
            bus_wr(4'h0, 32'd1 << b);
            exp = (b == 5 || b == 8) ? 32'd0 : (32'd1 << b);
            bus_rd(4'h0, rd); chk($sformatf("R2 ctrl bit %0d", b), rd, exp);
            chk("R2 ctrl_o", {16'd0, ctrl_o}, exp);
            bus_wr(4'h0, 32'd0);
        end
        bus_wr(4'h0, 32'hFFFF_0000);
        bus_rd(4'h0, rd); chk("R2 upper bits", rd, 0);
        bus_wr(4'h4, 32'h1F);
        bus_rd(4'h4, rd); chk("R6 cleared after sweep", rd, 0);

        // R12 handshake and unmapped address
        bus_wr(4'hC, 32'h1234_5678);
        chk("R12 ack high", {31'd0, obs_ack1}, 1);
        chk("R12 ack one cycle", {31'd0, obs_ack2}, 0);
        bus_rd(4'hC, rd); chk("R12 unmapped read", rd, 0);
        bus_rd(4'h8, rd); chk("R12 unmapped write ignored", rd, 0);

        // R5 holding register
        bus_wr(4'h8, 32'h5555_5555);
        bus_rd(4'h8, rd); chk("R5 pattern 55", rd, 32'h5555_5555);
        bus_wr(4'h8, 32'hAAAA_AAAA);
        bus_rd(4'h8, rd); chk("R5 pattern AA", rd, 32'hAAAA_AAAA);

        // R3 preload
        bus_wr(4'h0, 32'd1 << 5);
        chk("R3 strobe high", {31'd0, obs_pre1}, 1);
        chk("R3 strobe value", obs_pval, 32'hAAAA_AAAA);
        chk("R3 strobe one cycle", {31'd0, obs_pre2}, 0);
        chk("R3 core loaded", core_count, 32'hAAAA_AAAA);
        bus_rd(4'h0, rd); chk("R3 bit reads 0", rd, 0);

        // R4 latch
        bus_wr(4'h8, 32'hDEAD_DEAD);
        repeat (3) begin
            @(negedge clk); step_up = 1'b1;
            @(negedge clk); step_up = 1'b0;
        end
        bus_wr(4'h0, 32'd1 << 8);
        chk("R4 strobe high", {31'd0, obs_lat1}, 1);
        chk("R4 strobe one cycle", {31'd0, obs_lat2}, 0);
        bus_rd(4'h8, rd); chk("R4 captured count", rd, 32'hAAAA_AAAD);
        bus_rd(4'h0, rd); chk("R4 bit reads 0", rd, 0);

        // R6 and R8: each pulsed event with its enable off and on
        for (int e = 0; e < 3; e++) begin
            for (int en = 0; en < 2; en++) begin
                bus_wr(4'h0, en ? (32'd1 << en_pos[e]) : 32'd0);
                pulse(e);
                bus_rd(4'h4, rd); chk($sformatf("R6 set bit %0d", e), rd, 32'd1 << e);
                chk($sformatf("R8 irq ev %0d en %0d", e, en), {31'd0, irq}, en);
                bus_wr(4'h4, 32'd0);
                bus_rd(4'h4, rd); chk("R6 write 0 keeps", rd, 32'd1 << e);
                bus_wr(4'h4, 32'd1 << e);
                bus_rd(4'h4, rd); chk("R6 w1c clears", rd, 0);
                chk("R8 irq drops", {31'd0, irq}, 0);
            end
        end
        bus_wr(4'h0, 32'd0);

        // R7 set and clear in the same cycle
        pulse(2);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 32'd4;
        evt_unf = 1'b1;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0; evt_unf = 1'b0;
        @(posedge clk); #1;
        bus_rd(4'h4, rd); chk("R7 set wins", rd, 32'd4);
        bus_wr(4'h4, 32'd4);
        bus_rd(4'h4, rd); chk("R7 later clear", rd, 0);

        // R9 level index flag
        bus_wr(4'h0, (32'd1 << 2) | (32'd1 << 4));
        @(negedge clk); idx_active = 1'b1;
        wait_cyc(2);
        bus_rd(4'h4, rd); chk("R9 index sets", rd, 32'd8);
        chk("R9 irq", {31'd0, irq}, 1);
        bus_wr(4'h4, 32'd8);
        bus_rd(4'h4, rd); chk("R9 resets while present", rd, 32'd8);
        chk("R9 irq held", {31'd0, irq}, 1);
        @(negedge clk); idx_active = 1'b0;
        bus_wr(4'h4, 32'd8);
        bus_rd(4'h4, rd); chk("R9 clear after release", rd, 0);
        chk("R9 irq released", {31'd0, irq}, 0);

        // R11 index capture into holding register
        bus_wr(4'h8, 32'd0);
        bus_wr(4'h0, (32'd1 << 2) | (32'd1 << 13));
        @(negedge clk); idx_active = 1'b1;
        wait_cyc(2);
        bus_rd(4'h8, rd); chk("R11 captured", rd, 32'hAAAA_AAAD);
        @(negedge clk); idx_active = 1'b0;
        bus_wr(4'h0, 32'd1 << 2);
        bus_wr(4'h8, 32'h1234_5678);
        @(negedge clk); idx_active = 1'b1;
        wait_cyc(2);
        bus_rd(4'h8, rd); chk("R11 no capture", rd, 32'h1234_5678);
        @(negedge clk); idx_active = 1'b0;
        bus_wr(4'h0, 32'd0);
        bus_wr(4'h4, 32'h1F);

        // R10 compare match
        bus_wr(4'h0, (32'd1 << 14) | (32'd1 << 15));
        wait_cyc(2);
        bus_rd(4'h4, rd); chk("R10 differ", rd, 0);
        chk("R10 irq off", {31'd0, irq}, 0);
        bus_wr(4'h8, 32'hAAAA_AAAD);
        bus_rd(4'h4, rd); chk("R10 match", rd, 32'h10);
        chk("R10 irq on", {31'd0, irq}, 1);
        bus_wr(4'h8, 32'd0);
        bus_wr(4'h4, 32'h10);
        bus_rd(4'h4, rd); chk("R10 cleared", rd, 0);
        bus_wr(4'h0, 32'd1 << 15);
        bus_wr(4'h8, 32'hAAAA_AAAD);
        wait_cyc(2);
        bus_rd(4'h4, rd); chk("R10 disabled", rd, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule